// File: doc/BRIEF.md
# Digit-Serial Adder, Least Significant Digit First

This block adds two W-bit operands that are streamed in one J-bit digit per clock, lowest digit first. The operands may be unsigned or two's complement; the result is the W-bit sum modulo 2^W either way. Inside one cycle, J full-adder cells form a ripple chain across the digit. The carry leaving the top cell is held in a single register and enters the bottom cell on the next accepted digit. This is the bit-serial adder unfolded J times. It runs at the same clock rate and moves J bits per cycle instead of one.

A producer presents a digit of each operand together with a valid strobe. On the first digit of every word it also raises a word-start strobe, which forces the incoming carry to zero. The sum digit is available combinationally in the same cycle. It is also registered, with a matching valid, a last-digit marker and the word's final carry-out, one cycle later. Idle cycles may be inserted anywhere, including between the digits of a word.

Top module: `dserial_add`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, word_last and carry_flag become 0 and the stored carry becomes 0, so the first digit accepted after reset without word_start is added with a zero carry-in.
- R2: In every cycle, sum_dig equals the low J bits of a_dig + b_dig + cin, where bit 0 is the least significant bit and cin is the carry-in of bit position 0.
- R3: On a cycle with in_valid high, the carry out of bit position J-1 is stored and used as cin for the next digit accepted with word_start low.
- R4: When word_start is high, cin is 0 whatever the stored carry holds.
- R5: In cycles with in_valid low, the stored carry and the digit position do not change, whatever the other inputs are.
- R6: One cycle after an edge that samples in_valid high, out_valid is 1 and sum_dig_q holds that cycle's sum_dig. After an edge that samples in_valid low, out_valid is 0.
- R7: word_last is 1 with the registered output of the (W/J)-th valid digit counted from word_start, and 0 otherwise. When word_last is 1, carry_flag is the carry out of that digit, which is bit W of the full sum; otherwise carry_flag is 0.
- R8: The W/J registered sum digits of a word, placed at bit offsets 0, J, 2J and so on, reassemble to (a + b) mod 2^W for every operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies the digits on a_dig and b_dig |
| word_start | input | 1 | Marks the first (lowest) digit of a word; clears carry-in |
| a_dig | input | J | Current digit of operand A |
| b_dig | input | J | Current digit of operand B |
| sum_dig | output | J | Combinational sum digit |
| sum_dig_q | output | J | Registered sum digit |
| out_valid | output | 1 | Registered valid for sum_dig_q |
| word_last | output | 1 | Registered: sum_dig_q is the top digit of a word |
| carry_flag | output | 1 | Carry out of the word, meaningful with word_last |

## Verification
On every cycle the assertions check several properties: the ripple chain's arithmetic against the digit inputs and the carry-in, that the stored carry holds across idle cycles, that a word start with zero digits yields a zero digit, the registered output's valid and capture timing, and the qualification of the last-digit and carry flags. Other behaviours need the bench's scenarios: carry propagation across digit boundaries and reassembly of full words over every operand pair, idle gaps inside words, a word restarted while a carry is pending, and the reset clearing a carry that would otherwise leak into the first digit.

// File: rtl/dsa_pkg.sv
// Package: shared helpers for the digit-serial adder.
// Assumes: counts passed in are positive.
package dsa_pkg;

    // Width of a counter that indexes n items; at least one bit.
    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dsa_fa_cell.sv
// Module: one full-adder cell, the unit that the digit chain repeats.
// Assumes: purely combinational, single-bit operands.
module dsa_fa_cell (
    input  logic a_bit,
    input  logic b_bit,
    input  logic c_in,
    output logic s_bit,
    output logic c_out
);
    logic prop;

    // Sum and carry of one bit position.
    always_comb begin
        prop  = a_bit ^ b_bit;
        s_bit = prop ^ c_in;
        c_out = (a_bit & b_bit) | (c_in & prop);
    end
endmodule

// File: rtl/dsa_ripple.sv
// Module: J full-adder cells chained so a carry ripples across one digit
// inside a single cycle. Bit 0 is the least significant position.
// Assumes: DIG >= 1.
module dsa_ripple #(
    parameter int DIG = 2
) (
    input  logic [DIG-1:0] a_d,
    input  logic [DIG-1:0] b_d,
    input  logic           c_lo,
    output logic [DIG-1:0] s_d,
    output logic           c_hi
);
    logic [DIG:0] chain;

    // Carry into the lowest cell.
    assign chain[0] = c_lo;

    for (genvar i = 0; i < DIG; i++) begin : g_cell
        dsa_fa_cell u_cell (
            .a_bit (a_d[i]),
            .b_bit (b_d[i]),
            .c_in  (chain[i]),
            .s_bit (s_d[i]),
            .c_out (chain[i+1])
        );
    end

    // Carry leaving the highest cell.
    assign c_hi = chain[DIG];
endmodule

// File: rtl/dsa_word_track.sv
// Module: tracks which digit of the current word is being accepted and
// flags the top digit. A start strobe forces position 0.
// Assumes: NDIG >= 1; the position moves only on accepted digits.
module dsa_word_track #(
    parameter int NDIG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic first,
    output logic is_last
);
    import dsa_pkg::*;
    localparam int CW = idx_width(NDIG);
    localparam logic [CW-1:0] TOP = CW'(NDIG - 1);

    logic [CW-1:0] pos_q;
    logic [CW-1:0] idx;

    // Position of the digit on the inputs this cycle.
    always_comb begin
        idx     = first ? '0 : pos_q;
        is_last = (idx == TOP);
    end

    // Advance the position on each accepted digit, wrapping after the top one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (step)
            pos_q <= is_last ? '0 : idx + CW'(1);
    end

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pos_q) < NDIG); // R7

    AST_POS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pos_q)); // R5
endmodule

// File: rtl/dserial_add.sv
// Module: digit-serial adder, lowest digit first. Each accepted cycle adds
// one J-bit digit of each operand plus the carry kept from the previous
// digit; word_start clears that carry. Outputs a combinational digit and a
// registered digit with valid, last-digit marker and the word's carry-out.
// Assumes: W is a whole multiple of J.
module dserial_add #(
    parameter int W = 4,
    parameter int J = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         word_start,
    input  logic [J-1:0] a_dig,
    input  logic [J-1:0] b_dig,
    output logic [J-1:0] sum_dig,
    output logic [J-1:0] sum_dig_q,
    output logic         out_valid,
    output logic         word_last,
    output logic         carry_flag
);
    localparam int NDIG = W / J;

    if ((W % J) != 0 || J < 1) begin : g_bad_cfg
        $error("dserial_add: W must be a positive multiple of J");
    end

    logic carry_q;
    logic cin;
    logic ripple_cout;
    logic at_top;

    // Carry-in of bit 0: cleared at a word boundary, else the kept carry.
    assign cin = word_start ? 1'b0 : carry_q;

    dsa_ripple #(.DIG(J)) u_ripple (
        .a_d  (a_dig),
        .b_d  (b_dig),
        .c_lo (cin),
        .s_d  (sum_dig),
        .c_hi (ripple_cout)
    );

    dsa_word_track #(.NDIG(NDIG)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (in_valid),
        .first   (word_start),
        .is_last (at_top)
    );

    // Keep the top cell's carry for the next accepted digit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (in_valid)
            carry_q <= ripple_cout;
    end

    // Register the digit with its valid, last marker and word carry-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            word_last  <= 1'b0;
            carry_flag <= 1'b0;
            sum_dig_q  <= '0;
        end else begin
            out_valid  <= in_valid;
            word_last  <= in_valid & at_top;
            carry_flag <= in_valid & at_top & ripple_cout;
            if (in_valid)
                sum_dig_q <= sum_dig;
        end
    end

    AST_RIPPLE_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
        {ripple_cout, sum_dig} == (J+1)'(a_dig) + (J+1)'(b_dig) + (J+1)'(cin)); // R2

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start && a_dig == '0 && b_dig == '0) |-> (sum_dig == '0)); // R4

    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(carry_q)); // R5

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6

    AST_SUM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (sum_dig_q == $past(sum_dig))); // R6

    AST_LAST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        word_last |-> out_valid); // R7

    AST_CARRY_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        carry_flag |-> word_last); // R7
endmodule

// File: tb/dserial_add_test.sv
// Bench: exhaustive sweep of all operand pairs for W=4, J=2, with and
// without idle gaps, plus reset and word-restart corner cases.
module dserial_add_test;
    localparam int W    = 4;
    localparam int J    = 2;
    localparam int NDIG = W / J;
    localparam int DMSK = (1 << J) - 1;
    localparam int WMSK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         word_start;
    logic [J-1:0] a_dig;
    logic [J-1:0] b_dig;
    logic [J-1:0] sum_dig;
    logic [J-1:0] sum_dig_q;
    logic         out_valid;
    logic         word_last;
    logic         carry_flag;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dserial_add #(.W(W), .J(J)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .word_start (word_start),
        .a_dig      (a_dig),
        .b_dig      (b_dig),
        .sum_dig    (sum_dig),
        .sum_dig_q  (sum_dig_q),
        .out_valid  (out_valid),
        .word_last  (word_last),
        .carry_flag (carry_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One idle cycle with junk on the data and start inputs.
    task automatic idle_cycle(input int junk);
        in_valid   = 1'b0;
        word_start = junk[0];
        a_dig      = J'(junk >> 1);
        b_dig      = J'(junk >> 3);
        @(posedge clk);
        @(negedge clk);
        chk("R6 idle out_valid", int'(out_valid), 0);
        chk("R7 idle word_last", int'(word_last), 0);
    endtask

    // Stream one word, lowest digit first, and check every output.
    task automatic send_word(input int a, input int b, input bit gaps);
        int full = a + b;
        int rebuilt = 0;
        for (int k = 0; k < NDIG; k++) begin
            in_valid   = 1'b1;
            word_start = (k == 0);
            a_dig      = J'(a >> (k * J));
            b_dig      = J'(b >> (k * J));
            #1;
            chk((k == 0) ? "R2 first digit" : "R3 carried digit",
                int'(sum_dig), (full >> (k * J)) & DMSK);
            @(posedge clk);
            @(negedge clk);
            chk("R6 out_valid", int'(out_valid), 1);
            chk("R6 sum_dig_q", int'(sum_dig_q), (full >> (k * J)) & DMSK);
            chk("R7 word_last", int'(word_last), (k == NDIG - 1) ? 1 : 0);
            chk("R7 carry_flag", int'(carry_flag),
                (k == NDIG - 1) ? ((full >> W) & 1) : 0);
            rebuilt |= int'(sum_dig_q) << (k * J);
            if (gaps && k < NDIG - 1)
                idle_cycle(a * 7 + b * 3 + k);
        end
        chk("R8 word result", rebuilt, full & WMSK);
    endtask

    // Watchdog: a hung run ends as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        in_valid   = 1'b1;   // digits that would set a carry if not in reset
        word_start = 1'b0;
        a_dig      = J'(DMSK);
        b_dig      = J'(DMSK);
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", int'(out_valid), 0);
        chk("R1 reset word_last", int'(word_last), 0);
        chk("R1 reset carry_flag", int'(carry_flag), 0);

        // R1: first digit after reset, no word_start, adds with zero carry.
        rst_n      = 1'b1;
        in_valid   = 1'b1;
        word_start = 1'b0;
        a_dig      = J'(1);
        b_dig      = J'(0);
        #1;
        chk("R1 carry cleared by reset", int'(sum_dig), 1);
        @(posedge clk);
        @(negedge clk);

        // R4: leave a carry pending, then restart a word with zero digits.
        in_valid   = 1'b1;
        word_start = 1'b1;
        a_dig      = J'(DMSK);
        b_dig      = J'(1);
        @(posedge clk);
        @(negedge clk);
        idle_cycle(0);   // R5: pending carry must survive the gap
        in_valid   = 1'b1;
        word_start = 1'b0;
        a_dig      = '0;
        b_dig      = '0;
        #1;
        chk("R5 carry kept across gap", int'(sum_dig), 1);
        word_start = 1'b1;
        #1;
        chk("R4 word_start clears carry", int'(sum_dig), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 restart is not last digit", int'(word_last), 0);

        // Exhaustive sweep; every third pair uses gaps inside the word.
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                send_word(a, b, ((a + b) % 3) == 0);

        // Two's complement pair: -3 + 2 = -1.
        send_word((-3) & WMSK, 2, 1'b1);
        // Back-to-back words with carry out, no idle in between.
        send_word(WMSK, 1, 1'b0);
        send_word(1, 1, 1'b0);

        in_valid = 1'b0;
        @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule